// File: doc/BRIEF.md
# Guarded Multi-Bus Move Interconnect

This block is the transport network of a processor that is programmed by data moves, not by operations. Each instruction word carries one slot per transport bus. A slot names a source port, a destination port and an optional guard condition. In a single cycle every bus carries the value of its selected source to its selected destination, and all buses do this at once. Function units start work when their triggering input is written. Because any source can be routed to any destination, a result can go straight from one unit's output to another unit's input without passing through a register.

The data path is purely combinational: the instruction and the source read values go in, and the per-destination write enables and write data come out in the same cycle. The only state is a small bank of 1-bit guard registers. A move may be conditioned on one of these registers, in true or inverted sense, and a move whose condition fails is squashed. The guard registers are destinations like any other, so the program sets them with ordinary moves. When two surviving moves name the same destination, the move on the higher-numbered bus wins and a collision flag is raised.

Top module: `move_fabric`

## Requirements
- R1: Slot b occupies instruction bits [b*9 +: 9]. Inside a slot, bits [3:0] are the destination code, [5:4] the source index, [6] the guard register index and [8:7] the guard mode (defaults: 3 buses, 8-bit data, 4 sources, 8 destination ports, 2 guard registers).
- R2: Destination code 0, and codes 10 to 15, move nothing: no write enable rises and no guard register changes. Port 0's write enable is never asserted.
- R3: A surviving move to destination code d in 1..7 raises dst_we[d] and puts source value src_rdata[s*8 +: 8] on dst_wdata[d*8 +: 8] in the same cycle, whether the source is a unit result or a register. A destination that no surviving move writes has write enable 0 and write data 0.
- R4: All buses move in the same cycle. Moves to distinct destinations are all performed together.
- R5: Guard mode 0 always performs the move. Mode 1 performs it only when the selected guard register is 1. Mode 2 performs it only when that register is 0. Mode 3 always squashes it.
- R6: Destination codes 8 and 9 write bit 0 of the moved value into guard register 0 and 1 at the next clock edge. Guards evaluated in the same instruction still see the old value. guard_q shows the registers.
- R7: When two or more surviving moves target the same destination, the highest bus index wins and collide is 1 in that cycle. Squashed moves never count toward a collision. Otherwise collide is 0.
- R8: While rst_n is low, all guard registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the guard registers |
| instr | input | 27 | Instruction word, one 9-bit slot per bus |
| src_rdata | input | 32 | Read values of the 4 source ports, 8 bits each |
| dst_we | output | 8 | Write enable per destination port |
| dst_wdata | output | 64 | Write data per destination port, 8 bits each |
| guard_q | output | 2 | Current guard register values |
| collide | output | 1 | Two surviving moves named the same destination |

## Verification
The only internal state is the guard bank. A wrong guard bit appears on guard_q one edge after the move that should have set it. In the same cycle it also changes which guarded moves take place, so dst_we shows the error right away. Faults in decode, source selection and priority are combinational, so they appear on dst_we, dst_wdata and collide in the same cycle as the instruction. The sweep covers every slot field value on every bus, with guards in all states.

// File: rtl/move_fabric.sv
module move_fabric #(
  parameter int NBUS   = 3,
  parameter int DW     = 8,
  parameter int NSRC   = 4,
  parameter int NDST   = 8,
  parameter int NGUARD = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NBUS*((NDST+NGUARD > 1 ? $clog2(NDST+NGUARD) : 1)
                     + (NSRC > 1 ? $clog2(NSRC) : 1)
                     + (NGUARD > 1 ? $clog2(NGUARD) : 1) + 2)-1:0] instr,
  input  logic [NSRC*DW-1:0]    src_rdata,
  output logic [NDST-1:0]       dst_we,
  output logic [NDST*DW-1:0]    dst_wdata,
  output logic [NGUARD-1:0]     guard_q,
  output logic                  collide
);
  localparam int DSTW  = (NDST+NGUARD > 1) ? $clog2(NDST+NGUARD) : 1;
  localparam int SRCW  = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int GIW   = (NGUARD > 1) ? $clog2(NGUARD) : 1;
  localparam int SLOTW = DSTW + SRCW + GIW + 2;

  logic [NGUARD-1:0] g_we, g_d;

  always_comb begin
    int d, s, g, m;
    logic pass;
    logic [DW-1:0] v;
    dst_we    = '0;
    dst_wdata = '0;
    g_we      = '0;
    g_d       = guard_q;
    collide   = 1'b0;
    for (int b = 0; b < NBUS; b++) begin
      d = int'(instr[b*SLOTW +: DSTW]);
      s = int'(instr[b*SLOTW+DSTW +: SRCW]);
      g = int'(instr[b*SLOTW+DSTW+SRCW +: GIW]);
      m = int'(instr[b*SLOTW+DSTW+SRCW+GIW +: 2]);
      v = (s < NSRC) ? src_rdata[s*DW +: DW] : '0;
      case (m)
        0:       pass = 1'b1;
        1:       pass = (g < NGUARD) && guard_q[g];
        2:       pass = (g < NGUARD) && !guard_q[g];
        default: pass = 1'b0;
      endcase
      if (pass && d != 0) begin
        if (d < NDST) begin
          if (dst_we[d]) collide = 1'b1;
          dst_we[d] = 1'b1;
          dst_wdata[d*DW +: DW] = v;
        end else if (d < NDST + NGUARD) begin
          if (g_we[d-NDST]) collide = 1'b1;
          g_we[d-NDST] = 1'b1;
          g_d[d-NDST]  = v[0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) guard_q <= '0;
    else        guard_q <= g_d;
  end
endmodule

// File: rtl/move_fabric_chk.sv
module move_fabric_chk #(
  parameter int NBUS   = 3,
  parameter int DW     = 8,
  parameter int NSRC   = 4,
  parameter int NDST   = 8,
  parameter int NGUARD = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NBUS*((NDST+NGUARD > 1 ? $clog2(NDST+NGUARD) : 1)
                    + (NSRC > 1 ? $clog2(NSRC) : 1)
                    + (NGUARD > 1 ? $clog2(NGUARD) : 1) + 2)-1:0] instr,
  input logic [NDST-1:0]       dst_we,
  input logic [NDST*DW-1:0]    dst_wdata,
  input logic [NGUARD-1:0]     guard_q,
  input logic                  collide
);
  localparam int DSTW  = (NDST+NGUARD > 1) ? $clog2(NDST+NGUARD) : 1;
  localparam int SRCW  = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int GIW   = (NGUARD > 1) ? $clog2(NGUARD) : 1;
  localparam int SLOTW = DSTW + SRCW + GIW + 2;

  logic [NBUS-1:0] uncond;
  int              sd [NBUS];
  logic            any_g, dup;

  always_comb begin
    any_g = 1'b0;
    dup   = 1'b0;
    for (int b = 0; b < NBUS; b++) begin
      sd[b]     = int'(instr[b*SLOTW +: DSTW]);
      uncond[b] = (instr[b*SLOTW+DSTW+SRCW+GIW +: 2] == 2'd0) && sd[b] >= 1 && sd[b] < NDST;
      if (sd[b] >= NDST && sd[b] < NDST + NGUARD) any_g = 1'b1;
      for (int c = 0; c < b; c++)
        if (sd[c] == sd[b] && sd[b] != 0 && sd[b] < NDST + NGUARD) dup = 1'b1;
    end
  end

  a_r2_port0_idle: assert property (@(posedge clk) disable iff (!rst_n) !dst_we[0]);

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    a_r5_unguarded_moves: assert property (@(posedge clk) disable iff (!rst_n)
      uncond[b] |-> dst_we[sd[b]]);
  end

  for (genvar i = 0; i < NDST; i++) begin : g_dst
    a_r3_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !dst_we[i] |-> dst_wdata[i*DW +: DW] == '0);
  end

  a_r6_guard_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !any_g |=> $stable(guard_q));

  a_r7_collide_needs_dup: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> dup);
endmodule

bind move_fabric move_fabric_chk #(.NBUS(NBUS), .DW(DW), .NSRC(NSRC), .NDST(NDST), .NGUARD(NGUARD)) chk_i (.*);

// File: tb/move_fabric_tb_top.sv
module move_fabric_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [26:0] instr = '0;
  logic [31:0] src_rdata = '0;
  logic [7:0]  dst_we;
  logic [63:0] dst_wdata;
  logic [1:0]  guard_q;
  logic        collide;

  int n_run = 0, n_fail = 0;
  logic [1:0]  mg = 2'b00;
  logic [7:0]  e_we;
  logic [63:0] e_wd;
  logic        e_col;
  logic [1:0]  e_gn;

  always #4 clk = ~clk;

  move_fabric dut_i (.clk, .rst_n, .instr, .src_rdata, .dst_we, .dst_wdata, .guard_q, .collide);

  function automatic logic [8:0] mk(int gm, int gi, int s, int d);
    return {gm[1:0], gi[0], s[1:0], d[3:0]};
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model();
    logic [7:0]  taken;
    logic [1:0]  gt;
    e_we = '0; e_wd = '0; e_col = 1'b0; e_gn = mg; taken = '0; gt = '0;
    for (int b = 0; b < 3; b++) begin
      int d  = int'(instr[b*9 +: 4]);
      int s  = int'(instr[b*9+4 +: 2]);
      int gi = int'(instr[b*9+6]);
      int gm = int'(instr[b*9+7 +: 2]);
      bit ok = (gm == 0) || (gm == 1 && mg[gi]) || (gm == 2 && !mg[gi]);
      logic [7:0] v = src_rdata[s*8 +: 8];
      if (ok && d >= 1 && d <= 7) begin
        if (taken[d]) e_col = 1'b1;
        taken[d] = 1'b1; e_we[d] = 1'b1; e_wd[d*8 +: 8] = v;
      end else if (ok && (d == 8 || d == 9)) begin
        if (gt[d-8]) e_col = 1'b1;
        gt[d-8] = 1'b1; e_gn[d-8] = v[0];
      end
    end
  endtask

  task automatic step(string tag, logic [26:0] ins, logic [31:0] src);
    @(negedge clk);
    instr = ins; src_rdata = src;
    #2;
    model();
    chk(tag, "guard_q", 64'(guard_q), 64'(mg));
    chk(tag, "dst_we", 64'(dst_we), 64'(e_we));
    chk(tag, "dst_wdata", dst_wdata, e_wd);
    chk(tag, "collide", 64'(collide), 64'(e_col));
    @(posedge clk);
    #1 mg = e_gn;
  endtask

  localparam logic [31:0] SV = 32'h3C_A5_81_17;

  initial begin
    #(8*200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R8: reset state
    instr = {mk(0,0,1,8), mk(0,0,1,9), 9'd0};
    src_rdata = 32'hFFFF_FFFF;
    repeat (2) @(posedge clk);
    #1 chk("R8", "guard_q in reset", 64'(guard_q), 64'd0);
    @(negedge clk); rst_n = 1'b1; instr = '0;

    // R1, R3: one slot per bus, field positions, bypass from any source
    step("R1", {9'd0, 9'd0, mk(0,0,2,5)}, SV);
    step("R1", {9'd0, mk(0,0,3,6), 9'd0}, SV);
    step("R3", {mk(0,1,1,1), 9'd0, 9'd0}, SV);

    // R2: reserved and unused codes
    step("R2", {mk(0,0,1,0), mk(0,0,2,10), mk(0,0,3,15)}, SV);
    chk("R2", "guard_q after noop", 64'(guard_q), 64'(mg));

    // R4: three parallel moves
    step("R4", {mk(0,0,0,7), mk(0,0,1,4), mk(0,0,2,2)}, SV);

    // R6: guard set now, used next
    step("R6", {mk(1,0,0,3), 9'd0, mk(0,0,0,8)}, 32'h0000_0001);
    chk("R6", "guard0 set", 64'(guard_q), 64'd1);
    step("R6", {9'd0, 9'd0, mk(1,0,1,3)}, SV);

    // R5: inverted and never modes
    step("R5", {mk(2,0,1,1), mk(3,1,2,2), mk(2,1,3,3)}, SV);

    // R7: collisions, priority, squashed moves ignored
    step("R7", {mk(0,0,3,4), mk(0,0,2,4), mk(0,0,1,4)}, SV);
    step("R7", {mk(3,0,3,4), 9'd0, mk(0,0,1,4)}, SV);
    step("R7", {mk(0,0,0,9), mk(0,0,3,9), 9'd0}, SV);

    // R5, R3, R6: sweep of every field on every bus, all guard states
    for (int gs = 0; gs < 4; gs++) begin
      step("R6", {9'd0, mk(0,0,1,9), mk(0,0,0,8)},
           {16'h0, 7'h0, gs[1], 7'h0, gs[0]});
      for (int b = 0; b < 3; b++)
        for (int d = 0; d < 16; d++)
          for (int s = 0; s < 4; s++)
            for (int gm = 0; gm < 4; gm++)
              for (int gi = 0; gi < 2; gi++) begin
                logic [26:0] w = '0;
                w[b*9 +: 9] = mk(gm, gi, s, d);
                step("R5", w, {8'(d*29+gm), 8'(s*53+gi), 8'(b*71+d), 8'(gs*13+d+gm)});
              end
    end

    // R7, R4: mixed multi-slot patterns
    for (int k = 0; k < 600; k++) begin
      logic [26:0] w = 27'(k * 32'h9E37_79B1 ^ (k << 11));
      step("R7", w, 32'(k * 32'h6C07_8965 + 1));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule